// File: doc/BRIEF.md
# Interval Timer Channel

A single 16-bit down-counting timer channel of the kind found in PC-compatible interval timers. It advances on a one-cycle tick enable that runs at a nominal 1193182 Hz. A host-side register block, which is not part of this block, presents a reload value and an operating-mode code and pulses a load strobe. The channel then runs through its run states, counts while its gate input is high, and drives an output pin and a one-cycle interrupt pulse according to the selected mode.

A load does not take effect at once. The channel waits in a pending state until the next tick, and only then copies the reload value into the counter. In square-wave mode the reload value is made even before every use. A rate-generator reload written while that mode is already running does not disturb the count in progress. The new value is picked up at the next terminal count. The current count and run state are brought out so that a read path can sample them.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset the run state is 0 (idle), the count is 0, the output pin is low and no interrupt pulse is raised.
- R2: Run states are encoded 0 idle, 1 pending and 2 running. A load strobe moves the channel to pending on the next clock edge. The first tick after that copies the reload value into the count and moves the channel to running.
- R3: While running, the count decreases by one on each tick that arrives with the gate high. It holds when there is no tick or when the gate is low.
- R4: A reload value of 0 gives a period of 65536 ticks. The count reads 0 after the load and wraps to 65535 on the first tick.
- R5: Mode code 0 (interrupt on terminal count): a load drives the output low. The tick that finds the count at 1 (terminal count) drives the output high and raises a one-cycle interrupt pulse.
- R6: Mode code 2 (rate generator): a load drives the output high. Every terminal count raises an interrupt pulse and reloads the count, so interrupts recur every reload-value ticks.
- R7: In mode 2, a load strobe with mode code 2 while the channel is already running in mode 2 keeps the channel running and leaves the count untouched. The new reload value is used from the next terminal count onward.
- R8: Mode code 3 (square wave): the reload value with bit 0 cleared is used both at the first load and at every automatic reload.
- R9: In mode 3 a load drives the output high. Every terminal count toggles the output, and an interrupt pulse is raised only when the output goes from low to high.
- R10: Mode code 4 (software strobe): the output pin is left as it was. A single interrupt pulse is raised at the first terminal count after a load, and none after that.
- R11: Mode codes 1 and 5, and the unused codes 6 and 7, are accepted and counted, but they never change the output pin and never raise an interrupt.
- R12: A load strobe that puts the channel into pending takes priority over a tick in the same cycle, and the count does not change in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle tick enable from the reference rate |
| gateIn | input | 1 | Gate; counting only while high |
| loadStb | input | 1 | Load strobe; captures reloadVal and modeSel |
| modeSel | input | 3 | Operating-mode code |
| reloadVal | input | 16 | Reload value (0 means 65536) |
| runState | output | 2 | Current run state |
| countVal | output | 16 | Current count |
| outPin | output | 1 | Channel output pin |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
The bench targets the off-by-one points of the terminal count. A design that counts on the load tick, or that checks for 0 instead of 1, shifts every interrupt by one tick. It covers the 65536-tick period of a zero reload, which a design with a narrow counter would cut short at 0. It covers the odd square-wave reload, where a design without the even-forcing would produce uneven half-periods. It covers the deferred rate-generator reload, where a careless design would restart the count or drop the new period. It also checks that strobe and unimplemented modes leave the output alone, and that a load arriving together with a tick suppresses the decrement.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_PEND = 2'd1,
    RS_RUN  = 2'd2
  } runState_t;

  localparam logic [2:0] MODE_TC_IRQ   = 3'd0;
  localparam logic [2:0] MODE_RATE     = 3'd2;
  localparam logic [2:0] MODE_SQUARE   = 3'd3;
  localparam logic [2:0] MODE_SW_STROBE = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReload;
    logic loadCounter;
    logic countEn;
    logic evenForce;
    logic autoReload;
  } itcStrobes_t;
endpackage

// File: rtl/itc_datapath.sv
module itc_datapath
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  itcStrobes_t      stb,
  input  logic [CNT_W-1:0] reloadIn,
  output logic [CNT_W-1:0] countVal,
  output logic             tcHit
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] reloadReg;
  logic [CNT_W-1:0] countReg;
  logic [CNT_W-1:0] effReload;

  // square wave uses an even reload value
  assign effReload = stb.evenForce ? {reloadReg[CNT_W-1:1], 1'b0} : reloadReg;
  assign tcHit     = stb.countEn && (countReg == CNT_ONE);
  assign countVal  = countReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadReg <= '0;
    end else if (stb.captureReload) begin
      reloadReg <= reloadIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= '0;
    end else if (stb.loadCounter) begin
      countReg <= effReload;
    end else if (stb.countEn) begin
      if (tcHit && stb.autoReload) begin
        countReg <= effReload;
      end else begin
        countReg <= countReg - CNT_ONE;
      end
    end
  end
endmodule

// File: rtl/itc_ctrl.sv
module itc_ctrl
  import itc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        gateIn,
  input  logic        loadStb,
  input  logic [2:0]  modeSel,
  input  logic        tcHit,
  output itcStrobes_t stb,
  output logic [1:0]  runState,
  output logic        outPin,
  output logic        irqPulse
);
  runState_t stateReg, stateNext;
  logic [2:0] modeReg;
  logic outReg, outNext;
  logic irqReg, irqNext;
  logic firedReg, firedNext;
  logic deferLoad, goPending;

  assign deferLoad = loadStb && (modeSel == MODE_RATE) && (modeReg == MODE_RATE)
                     && (stateReg == RS_RUN);
  assign goPending = loadStb && !deferLoad;

  always_comb begin
    stb.captureReload = loadStb;
    stb.loadCounter   = !goPending && (stateReg == RS_PEND) && tickEn;
    stb.countEn       = !goPending && (stateReg == RS_RUN) && tickEn && gateIn;
    stb.evenForce     = (modeReg == MODE_SQUARE);
    stb.autoReload    = (modeReg == MODE_RATE) || (modeReg == MODE_SQUARE);
  end

  always_comb begin
    stateNext = stateReg;
    outNext   = outReg;
    irqNext   = 1'b0;
    firedNext = firedReg;
    if (goPending) begin
      stateNext = RS_PEND;
      firedNext = 1'b0;
      case (modeSel)
        MODE_TC_IRQ:            outNext = 1'b0;
        MODE_RATE, MODE_SQUARE: outNext = 1'b1;
        default:                outNext = outReg;
      endcase
    end else begin
      if (stb.loadCounter) stateNext = RS_RUN;
      if (tcHit) begin
        case (modeReg)
          MODE_TC_IRQ: begin
            if (!outReg) begin
              outNext = 1'b1;
              irqNext = 1'b1;
            end
          end
          MODE_RATE: irqNext = 1'b1;
          MODE_SQUARE: begin
            outNext = !outReg;
            irqNext = !outReg;
          end
          MODE_SW_STROBE: begin
            irqNext   = !firedReg;
            firedNext = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateReg <= RS_IDLE;
      modeReg  <= MODE_TC_IRQ;
      outReg   <= 1'b0;
      irqReg   <= 1'b0;
      firedReg <= 1'b0;
    end else begin
      stateReg <= stateNext;
      outReg   <= outNext;
      irqReg   <= irqNext;
      firedReg <= firedNext;
      if (goPending) modeReg <= modeSel;
    end
  end

  assign runState = stateReg;
  assign outPin   = outReg;
  assign irqPulse = irqReg;
endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             gateIn,
  input  logic             loadStb,
  input  logic [2:0]       modeSel,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [1:0]       runState,
  output logic [CNT_W-1:0] countVal,
  output logic             outPin,
  output logic             irqPulse
);
  itcStrobes_t stb;
  logic tcHit;

  itc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .gateIn   (gateIn),
    .loadStb  (loadStb),
    .modeSel  (modeSel),
    .tcHit    (tcHit),
    .stb      (stb),
    .runState (runState),
    .outPin   (outPin),
    .irqPulse (irqPulse)
  );

  itc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reloadIn (reloadVal),
    .countVal (countVal),
    .tcHit    (tcHit)
  );
endmodule

// File: rtl/itc_checker.sv
module itc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             gateIn,
  input logic             loadStb,
  input logic [2:0]       modeSel,
  input logic [1:0]       runState,
  input logic [CNT_W-1:0] countVal,
  input logic             outPin,
  input logic             irqPulse
);
  assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    runState != 2'd3);

  assert_pend_to_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    (runState == 2'd1 && tickEn && !loadStb) |=> runState == 2'd2);

  assert_load_pending_R12: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && modeSel != 3'd2) |=> runState == 2'd1);

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    (runState == 2'd2 && !tickEn && !loadStb) |=> $stable(countVal));

  assert_hold_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (runState == 2'd2 && !gateIn && !loadStb) |=> $stable(countVal));

  assert_mode0_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && modeSel == 3'd0) |=> !outPin);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (runState == 2'd0) |-> !irqPulse);
endmodule

bind interval_timer_chan itc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .gateIn   (gateIn),
  .loadStb  (loadStb),
  .modeSel  (modeSel),
  .runState (runState),
  .countVal (countVal),
  .outPin   (outPin),
  .irqPulse (irqPulse)
);

// File: tb/interval_timer_chan_bench.sv
module interval_timer_chan_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic gateIn = 1'b1;
  logic loadStb = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic [15:0] reloadVal = 16'd0;
  logic [1:0] runState;
  logic [15:0] countVal;
  logic outPin;
  logic irqPulse;

  int nChecks = 0;
  int nErrs = 0;
  bit finished = 0;

  // behavioural reference state
  int mState, mCnt, mMode, mRel, mOut, mIrq, mFired;

  always #5 clk = ~clk;

  interval_timer_chan u_interval_timer_chan (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .gateIn(gateIn), .loadStb(loadStb),
    .modeSel(modeSel), .reloadVal(reloadVal), .runState(runState),
    .countVal(countVal), .outPin(outPin), .irqPulse(irqPulse)
  );

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrs);
      $finish;
    end
  endtask

  // reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mMode = 0; mRel = 0; mOut = 0; mIrq = 0; mFired = 0;
    end else begin
      int defer, pend, eff;
      defer = (loadStb && modeSel == 2 && mMode == 2 && mState == 2) ? 1 : 0;
      pend  = (loadStb && !defer) ? 1 : 0;
      mIrq  = 0;
      if (pend) begin
        mRel = reloadVal; mMode = modeSel; mState = 1; mFired = 0;
        if (modeSel == 0) mOut = 0;
        else if (modeSel == 2 || modeSel == 3) mOut = 1;
      end else begin
        eff = (mMode == 3) ? (mRel / 2) * 2 : mRel;
        if (mState == 1 && tickEn) begin
          mCnt = eff; mState = 2;
        end else if (mState == 2 && tickEn && gateIn) begin
          if (mCnt == 1) begin
            if (mMode == 0 && mOut == 0) begin mOut = 1; mIrq = 1; end
            else if (mMode == 2) mIrq = 1;
            else if (mMode == 3) begin mOut = 1 - mOut; mIrq = mOut; end
            else if (mMode == 4 && !mFired) begin mIrq = 1; mFired = 1; end
            else if (mMode == 4) mFired = 1;
            mCnt = (mMode == 2 || mMode == 3) ? eff : 0;
          end else begin
            mCnt = (mCnt + 65535) % 65536;
          end
        end
        if (loadStb) mRel = reloadVal;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 runState vs model", runState, mState);
      chk("R3 countVal vs model", countVal, mCnt);
      chk("R5 outPin vs model", outPin, mOut);
      chk("R6 irqPulse vs model", irqPulse, mIrq);
    end
  end

  task automatic doLoad(int mode, int rel, bit withTick = 0);
    modeSel = mode[2:0]; reloadVal = rel[15:0]; loadStb = 1'b1; tickEn = withTick;
    @(negedge clk);
    loadStb = 1'b0; tickEn = 1'b0;
  endtask

  task automatic step(int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErrs++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int prevOut, prevCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset runState", runState, 0);
    chk("R1 reset countVal", countVal, 0);
    chk("R1 reset outPin", outPin, 0);
    chk("R1 reset irqPulse", irqPulse, 0);

    // R2 / R5 mode 0
    doLoad(0, 5);
    chk("R2 pending after load", runState, 1);
    step(1);
    chk("R2 running after tick", runState, 2);
    chk("R2 count loaded", countVal, 5);
    step(4);
    chk("R3 count after 4 ticks", countVal, 1);
    chk("R5 out low before tc", outPin, 0);
    step(1);
    chk("R5 out high at tc", outPin, 1);
    chk("R5 irq at tc", irqPulse, 1);
    step(1);
    chk("R5 irq one cycle", irqPulse, 0);
    prevCnt = countVal;
    gateIn = 1'b0;
    step(3);
    chk("R3 gate low holds count", countVal, prevCnt);
    gateIn = 1'b1;

    // R4 zero reload
    doLoad(0, 0);
    step(1);
    chk("R4 zero reload count", countVal, 0);
    step(1);
    chk("R4 wrap to 65535", countVal, 65535);
    step(65534);
    chk("R4 one before tc", countVal, 1);
    chk("R4 no irq yet", outPin, 0);
    step(1);
    chk("R4 tc after 65536 ticks", irqPulse, 1);

    // R6 rate generator
    doLoad(2, 4);
    step(1);
    chk("R6 out high", outPin, 1);
    chk("R6 count loaded", countVal, 4);
    step(3);
    chk("R6 no irq before tc", irqPulse, 0);
    step(1);
    chk("R6 irq at tc", irqPulse, 1);
    chk("R6 auto reload", countVal, 4);
    step(4);
    chk("R6 periodic irq", irqPulse, 1);

    // R7 deferred reload
    doLoad(2, 6);
    chk("R7 stays running", runState, 2);
    chk("R7 count untouched", countVal, 4);
    step(3);
    chk("R7 old period continues", countVal, 1);
    step(1);
    chk("R7 irq at old period", irqPulse, 1);
    chk("R7 new reload at tc", countVal, 6);
    step(6);
    chk("R7 new period irq", irqPulse, 1);

    // R8 / R9 square wave, odd reload
    doLoad(3, 7);
    step(1);
    chk("R8 even count loaded", countVal, 6);
    chk("R9 out high after load", outPin, 1);
    step(5);
    step(1);
    chk("R9 out toggles low", outPin, 0);
    chk("R9 no irq on falling", irqPulse, 0);
    chk("R8 even auto reload", countVal, 6);
    step(6);
    chk("R9 out toggles high", outPin, 1);
    chk("R9 irq on rising", irqPulse, 1);

    // R10 software strobe
    prevOut = outPin;
    doLoad(4, 3);
    step(1);
    step(3);
    chk("R10 strobe irq", irqPulse, 1);
    chk("R10 out unchanged", outPin, prevOut);
    step(5);
    chk("R10 single strobe", irqPulse, 0);

    // R11 unimplemented modes
    prevOut = outPin;
    doLoad(1, 3);
    step(4);
    chk("R11 mode1 counted", countVal, 0);
    chk("R11 mode1 no irq", irqPulse, 0);
    chk("R11 mode1 out unchanged", outPin, prevOut);
    doLoad(5, 2);
    step(3);
    chk("R11 mode5 counted", countVal, 0);
    chk("R11 mode5 out unchanged", outPin, prevOut);

    // R12 load with simultaneous tick
    doLoad(2, 9);
    step(3);
    prevCnt = countVal;
    doLoad(0, 2, 1'b1);
    chk("R12 pending wins over tick", runState, 1);
    chk("R12 count held", countVal, prevCnt);
    step(1);
    chk("R12 loaded on next tick", countVal, 2);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      tickEn = ($urandom_range(0, 2) != 0);
      gateIn = ($urandom_range(0, 9) != 0);
      if (r < 3) begin
        modeSel = (r == 0) ? 3'd0 : ((r == 1) ? 3'd2 : 3'd3);
        reloadVal = 16'($urandom_range(0, 12));
        loadStb = 1'b1;
      end else begin
        loadStb = 1'b0;
      end
      @(negedge clk);
    end
    loadStb = 1'b0; tickEn = 1'b0;
    @(negedge clk);
    summary();
  end
endmodule